// File: doc/BRIEF.md
# CPU single-step clock and bus monitor

This block drives the two-phase clock and the active-low reset of a small 8-bit processor. It advances that clock only when a host asks. A host command can put the processor through a reset sequence, advance it by exactly one bus cycle, or run it until it reaches its next opcode fetch. In every bus cycle the block samples the processor's read/write strobe, its opcode-fetch indicator and its data bus just before the cycle ends. It then offers the host one record per cycle on a valid/ready output.

Each cycle starts when PHI2 falls. The low phase comes first and gives the processor time to settle its address and control outputs. The high phase follows, and the cycle ends on the next fall of PHI2. Both phase lengths are set in system clocks by inputs, and each is held to at least two clocks. Every record carries a running count of the cycles completed since the last reset command, a cycle type, and the sampled data byte. The host can use the records to follow the processor one cycle at a time.

Top module: `cpu_step_ctrl`

## Requirements
- R1: A reset command (`cmd_op` = 2'b01) drives `resb` low for RST_CYCLES complete PHI2 cycles (default 2, at least 2). No record is produced during those cycles. The command clears the cycle count, so the first record after it carries count 1.
- R2: A cycle command (`cmd_op` = 2'b10) produces exactly one PHI2 cycle (one rise and one fall) and exactly one record. That record becomes valid on the same clock edge on which PHI2 falls.
- R3: After a step command is accepted, PHI2 stays low for max(`lo_len`,2) system clocks and is then high for max(`hi_len`,2) system clocks. So `rec_valid` is first seen max(`lo_len`,2)+max(`hi_len`,2) clocks after the accepting edge.
- R4: `rec_kind` is 2'b10 (opcode fetch) when SYNC and RWB are both high. It is 2'b01 (write) when RWB is low, whatever SYNC is. It is 2'b00 (read) otherwise. The code 2'b11 never appears.
- R5: `rec_data` equals the processor data bus as sampled on the last system clock edge of the high phase.
- R6: Each record's `rec_count` is one more than the previous record's count since the last reset command.
- R7: An instruction command (`cmd_op` = 2'b11) runs consecutive cycles and records each one. It waits for each record to be accepted before starting the next cycle. It stops after the first cycle, other than its own first cycle, that is classified as an opcode fetch.
- R8: Any command given while a step or reset is in progress, or while a record is waiting to be accepted, is ignored. No PHI2 rise follows from it.
- R9: While `rec_valid` is high and `rec_ready` is low, the record fields stay unchanged. A cycle with both high removes the record.
- R10: After the block's own reset, PHI2 is low, RESB is high, no record is valid, and the cycle count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_valid | input | 1 | Command strobe, sampled each clock |
| cmd_op | input | 2 | 01 reset, 10 one cycle, 11 one instruction |
| lo_len | input | PW | PHI2 low-phase length in clocks (min 2 applied) |
| hi_len | input | PW | PHI2 high-phase length in clocks (min 2 applied) |
| cpu_rwb | input | 1 | Processor read/write strobe (high = read) |
| cpu_sync | input | 1 | Processor opcode-fetch indicator |
| cpu_data | input | DW | Processor data bus |
| phi2 | output | 1 | Processor clock |
| resb | output | 1 | Processor reset, active low |
| rec_valid | output | 1 | Cycle record available |
| rec_ready | input | 1 | Host accepts the record |
| rec_count | output | CW | Cycles since the last reset command, including this one |
| rec_kind | output | 2 | 00 read, 01 write, 10 opcode fetch |
| rec_data | output | DW | Data bus value captured in the cycle |

## Verification
Each record is due a fixed number of clocks after the accepting edge: the sum of the two clamped phase lengths. The bench counts falling clock edges from acceptance until `rec_valid` appears and compares that count with the sum it computes itself. During the same wait it counts how many sampled clocks find PHI2 high and how many find it low, which checks each phase length. The bench drives the processor bus from a table indexed by its own count of PHI2 falls, so the expected type and data of each record come from the table and not from the design. For the checks that a command is ignored, the bench watches PHI2 and `rec_valid` for a window well longer than one cycle.

// File: rtl/step_pkg.sv
package step_pkg;
  localparam logic [1:0] CMD_NONE  = 2'b00;
  localparam logic [1:0] CMD_RESET = 2'b01;
  localparam logic [1:0] CMD_CYCLE = 2'b10;
  localparam logic [1:0] CMD_INSTR = 2'b11;

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/step_rst_sync.sv
module step_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/step_phase_timer.sv
module step_phase_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] len,
  output logic          zero
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = len - 1'b1;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/step_bus_classify.sv
module step_bus_classify
  import step_pkg::*;
(
  input  logic       rwb,
  input  logic       sync,
  output logic [1:0] kind
);
  always_comb begin
    if (!rwb)      kind = KIND_WRITE;
    else if (sync) kind = KIND_FETCH;
    else           kind = KIND_READ;
  end
endmodule

// File: rtl/step_cycle_counter.sv
module step_cycle_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] next_value
);
  logic [CW-1:0] value_q, value_d;

  assign next_value = value_q + 1'b1;

  always_comb begin
    value_d = value_q;
    if (clear)    value_d = '0;
    else if (inc) value_d = next_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end
endmodule

// File: rtl/step_rec_stage.sv
module step_rec_stage #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count_in,
  input  logic [1:0]    kind_in,
  input  logic [DW-1:0] data_in,
  input  logic          ready,
  output logic          valid,
  output logic [CW-1:0] count,
  output logic [1:0]    kind,
  output logic [DW-1:0] data
);
  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (load)       valid_d = 1'b1;
    else if (ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      kind  <= '0;
      data  <= '0;
    end else if (load) begin
      count <= count_in;
      kind  <= kind_in;
      data  <= data_in;
    end
  end
endmodule

// File: rtl/cpu_step_ctrl.sv
module cpu_step_ctrl
  import step_pkg::*;
#(
  parameter int CW         = 16,
  parameter int DW         = 8,
  parameter int PW         = 8,
  parameter int RST_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [PW-1:0] lo_len,
  input  logic [PW-1:0] hi_len,
  input  logic          cpu_rwb,
  input  logic          cpu_sync,
  input  logic [DW-1:0] cpu_data,
  output logic          phi2,
  output logic          resb,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [CW-1:0] rec_count,
  output logic [1:0]    rec_kind,
  output logic [DW-1:0] rec_data
);
  localparam int RSTW = $clog2(RST_CYCLES + 1);
  localparam logic [PW-1:0] MIN_PHASE = PW'(2);

  logic rst_n_i;
  step_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // Clamp phase lengths to the minimum of two clocks
  logic [PW-1:0] lo_eff, hi_eff;
  assign lo_eff = (lo_len < MIN_PHASE) ? MIN_PHASE : lo_len;
  assign hi_eff = (hi_len < MIN_PHASE) ? MIN_PHASE : hi_len;

  logic          tmr_load, tmr_zero;
  logic [PW-1:0] tmr_len;
  step_phase_timer #(.PW(PW)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .load(tmr_load), .len(tmr_len), .zero(tmr_zero)
  );

  logic [1:0] cls_kind;
  step_bus_classify u_cls (.rwb(cpu_rwb), .sync(cpu_sync), .kind(cls_kind));

  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] cnt_next;
  step_cycle_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .clear(cnt_clr), .inc(cnt_inc), .next_value(cnt_next)
  );

  logic rec_load;
  step_rec_stage #(.CW(CW), .DW(DW)) u_rec (
    .clk(clk), .rst_n(rst_n_i), .load(rec_load),
    .count_in(cnt_next), .kind_in(cls_kind), .data_in(cpu_data),
    .ready(rec_ready), .valid(rec_valid),
    .count(rec_count), .kind(rec_kind), .data(rec_data)
  );

  seq_state_e      state_q, state_d;
  logic            phi2_q, phi2_d;
  logic            resb_q, resb_d;
  logic            instr_q, instr_d;
  logic            first_q, first_d;
  logic            inrst_q, inrst_d;
  logic [RSTW-1:0] rleft_q, rleft_d;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    phi2_d   = phi2_q;
    resb_d   = resb_q;
    instr_d  = instr_q;
    first_d  = first_q;
    inrst_d  = inrst_q;
    rleft_d  = rleft_q;
    tmr_load = 1'b0;
    tmr_len  = lo_eff;
    rec_load = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid && !rec_valid) begin
          if (cmd_op == CMD_RESET) begin
            inrst_d  = 1'b1;
            resb_d   = 1'b0;
            rleft_d  = RSTW'(RST_CYCLES - 1);
            cnt_clr  = 1'b1;
            tmr_load = 1'b1;
            state_d  = ST_LOW;
          end else if (cmd_op == CMD_CYCLE || cmd_op == CMD_INSTR) begin
            instr_d  = (cmd_op == CMD_INSTR);
            first_d  = 1'b1;
            tmr_load = 1'b1;
            state_d  = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_len  = hi_eff;
          phi2_d   = 1'b1;
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          phi2_d = 1'b0;
          if (inrst_q) begin
            if (rleft_q == '0) begin
              resb_d  = 1'b1;
              inrst_d = 1'b0;
              state_d = ST_IDLE;
            end else begin
              rleft_d  = rleft_q - 1'b1;
              tmr_load = 1'b1;
              state_d  = ST_LOW;
            end
          end else begin
            rec_load = 1'b1;
            cnt_inc  = 1'b1;
            first_d  = 1'b0;
            if (!instr_q || (!first_q && cls_kind == KIND_FETCH)) state_d = ST_IDLE;
            else                                                   state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (!rec_valid) begin
          tmr_load = 1'b1;
          state_d  = ST_LOW;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      phi2_q  <= 1'b0;
      resb_q  <= 1'b1;
      instr_q <= 1'b0;
      first_q <= 1'b0;
      inrst_q <= 1'b0;
      rleft_q <= '0;
    end else begin
      state_q <= state_d;
      phi2_q  <= phi2_d;
      resb_q  <= resb_d;
      instr_q <= instr_d;
      first_q <= first_d;
      inrst_q <= inrst_d;
      rleft_q <= rleft_d;
    end
  end

  assign phi2 = phi2_q;
  assign resb = resb_q;
endmodule

// File: rtl/step_ctrl_checker.sv
module step_ctrl_checker #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phi2,
  input logic          resb,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [CW-1:0] rec_count,
  input logic [1:0]    rec_kind,
  input logic [DW-1:0] rec_data
);
  // R9: pending record is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_count) && $stable(rec_kind) && $stable(rec_data));

  // R2: a record appears only with a fall of PHI2
  a_r2_rec_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> $fell(phi2));

  // R4: reserved type code never reported
  a_r4_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_kind != 2'b11);

  // R3: each phase lasts at least two clocks
  a_r3_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |=> phi2);
  a_r3_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |=> !phi2);

  // R1: no record while the processor is held in reset
  a_r1_no_rec_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !resb |-> !rec_valid);
endmodule

bind cpu_step_ctrl step_ctrl_checker #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .resb(resb),
  .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_count(rec_count), .rec_kind(rec_kind), .rec_data(rec_data)
);

// File: tb/cpu_step_ctrl_bench.sv
module cpu_step_ctrl_bench;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int PW = 8;
  localparam int NV = 8;

  // {rwb, sync, expected kind, data}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'b10, 8'hA9},
    {1'b1, 1'b0, 2'b00, 8'h42},
    {1'b0, 1'b0, 2'b01, 8'h42},
    {1'b1, 1'b1, 2'b10, 8'h8D},
    {1'b1, 1'b0, 2'b00, 8'h00},
    {1'b0, 1'b1, 2'b01, 8'h55},
    {1'b1, 1'b0, 2'b00, 8'h02},
    {1'b1, 1'b1, 2'b10, 8'hEA}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [PW-1:0] lo_len, hi_len;
  logic          cpu_rwb, cpu_sync;
  logic [DW-1:0] cpu_data;
  logic          phi2, resb, rec_valid, rec_ready;
  logic [CW-1:0] rec_count;
  logic [1:0]    rec_kind;
  logic [DW-1:0] rec_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int p      = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  cpu_step_ctrl #(.CW(CW), .DW(DW), .PW(PW), .RST_CYCLES(2)) u_cpu_step_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lo_len(lo_len), .hi_len(hi_len),
    .cpu_rwb(cpu_rwb), .cpu_sync(cpu_sync), .cpu_data(cpu_data),
    .phi2(phi2), .resb(resb), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_count(rec_count), .rec_kind(rec_kind), .rec_data(rec_data)
  );

  // Processor bus model: a new table entry after every fall of PHI2
  always @(negedge phi2) p = p + 1;
  assign cpu_rwb  = VEC[p % NV][11];
  assign cpu_sync = VEC[p % NV][10];
  assign cpu_data = VEC[p % NV][7:0];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send_cmd(input logic [1:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_rec(output int lat, output int lo_n, output int hi_n);
    lat = 0; lo_n = 0; hi_n = 0;
    while (!rec_valid && lat < 2000) begin
      if (phi2) hi_n++; else lo_n++;
      @(negedge clk); lat++;
    end
  endtask

  task automatic accept();
    @(negedge clk); rec_ready = 1'b1;
    @(negedge clk); rec_ready = 1'b0;
  endtask

  task automatic quiet_window(input int n, input string req);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (phi2 || rec_valid) bad = 1'b1;
    end
    check(!bad, req, int'(bad), 0);
  endtask

  initial begin
    int lat, lo_n, hi_n, p0, rises, lowclk, nrec, nexp, s, idx;
    logic [CW-1:0] sc; logic [1:0] sk; logic [DW-1:0] sd;
    bit stable_ok;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; rec_ready = 1'b0;
    lo_len = 8'd3; hi_len = 8'd4;
    repeat (3) @(negedge clk);
    // R10: state during and after block reset
    check(phi2 == 1'b0, "R10 phi2", int'(phi2), 0);
    check(resb == 1'b1, "R10 resb", int'(resb), 1);
    check(rec_valid == 1'b0, "R10 rec_valid", int'(rec_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: first record after block reset has count 1
    send_cmd(2'b10);
    wait_rec(lat, lo_n, hi_n);
    check(rec_count == 1, "R10 first count", int'(rec_count), 1);
    accept();

    // R1: reset command
    send_cmd(2'b01);
    rises = 0; lowclk = 0;
    begin
      logic prev = phi2;
      bit recbad = 1'b0;
      while (!resb && lowclk < 2000) begin
        if (phi2 && !prev) rises++;
        if (rec_valid) recbad = 1'b1;
        prev = phi2;
        @(negedge clk); lowclk++;
      end
      check(rises == 2, "R1 phi2 cycles in reset", rises, 2);
      check(lowclk == 14, "R1 resb low clocks", lowclk, 14);
      check(!recbad, "R1 no record during reset", int'(recbad), 0);
    end
    exp_cnt = 0;

    // Vector loop: single cycles, R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      p0 = p;
      send_cmd(2'b10);
      wait_rec(lat, lo_n, hi_n);
      exp_cnt++;
      check(lat == 7, "R3 latency", lat, 7);
      check(lo_n == 3 && hi_n == 4, "R3 phase lengths", lo_n * 100 + hi_n, 304);
      check(rec_kind == VEC[p0 % NV][9:8], "R4 kind", int'(rec_kind), int'(VEC[p0 % NV][9:8]));
      check(rec_data == VEC[p0 % NV][7:0], "R5 data", int'(rec_data), int'(VEC[p0 % NV][7:0]));
      check(rec_count == CW'(exp_cnt), "R6 count", int'(rec_count), exp_cnt);
      accept();
      check(p == p0 + 1, "R2 one cycle per command", p - p0, 1);
      check(!rec_valid, "R9 record removed on accept", int'(rec_valid), 0);
    end

    // R9 hold and R8 ignore while pending
    p0 = p;
    send_cmd(2'b10);
    wait_rec(lat, lo_n, hi_n);
    exp_cnt++;
    sc = rec_count; sk = rec_kind; sd = rec_data;
    send_cmd(2'b10);
    stable_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rec_valid || rec_count != sc || rec_kind != sk || rec_data != sd) stable_ok = 1'b0;
      if (phi2) stable_ok = 1'b0;
    end
    check(stable_ok, "R9 record held while not ready", int'(stable_ok), 1);
    accept();
    quiet_window(30, "R8 command ignored while record pending");
    check(p == p0 + 1, "R8 cycles while pending", p - p0, 1);

    // R8 ignore while a step is in progress
    p0 = p;
    send_cmd(2'b10);
    send_cmd(2'b11);
    wait_rec(lat, lo_n, hi_n);
    exp_cnt++;
    accept();
    quiet_window(30, "R8 command ignored while stepping");
    check(p == p0 + 1, "R8 cycles while stepping", p - p0, 1);

    // R7 instruction step
    s = p;
    nexp = 1;
    while (VEC[(s + nexp) % NV][9:8] != 2'b10 && nexp < NV) nexp++;
    nexp++;
    send_cmd(2'b11);
    nrec = 0;
    begin
      bit ok7 = 1'b1;
      bit done = 1'b0;
      while (!done && nrec < 3 * NV) begin
        wait_rec(lat, lo_n, hi_n);
        idx = (s + nrec) % NV;
        exp_cnt++;
        if (rec_kind != VEC[idx][9:8] || rec_data != VEC[idx][7:0]) ok7 = 1'b0;
        if (rec_count != CW'(exp_cnt)) ok7 = 1'b0;
        nrec++;
        if (nrec > 1 && VEC[idx][9:8] == 2'b10) done = 1'b1;
        accept();
      end
      check(ok7, "R7 records during instruction", int'(ok7), 1);
    end
    quiet_window(40, "R7 stops after next fetch");
    check(nrec == nexp, "R7 record count", nrec, nexp);

    // R3 clamp of short phase settings
    lo_len = 8'd0; hi_len = 8'd1;
    send_cmd(2'b10);
    wait_rec(lat, lo_n, hi_n);
    exp_cnt++;
    check(lat == 4, "R3 clamped latency", lat, 4);
    check(lo_n == 2 && hi_n == 2, "R3 clamped phases", lo_n * 100 + hi_n, 202);
    accept();

    // R1 reset clears the count
    lo_len = 8'd2; hi_len = 8'd5;
    send_cmd(2'b01);
    while (!resb) @(negedge clk);
    send_cmd(2'b10);
    wait_rec(lat, lo_n, hi_n);
    check(rec_count == 1, "R1 count after reset", int'(rec_count), 1);
    check(lat == 7, "R3 latency 2+5", lat, 7);
    accept();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule